// File: doc/BRIEF.md
# SMBus Slave with Alert Response

This block is the bus-facing side of a monitoring peripheral. It watches oversampled SCL and SDA lines, pulls SDA low through an open-drain enable, and drives an active-low alert pin. A master can point at one of a few byte registers with a one-byte write and then fetch the selected byte with a Receive Byte read. The peripheral's monitoring logic supplies an alert-request level, and the block samples it on a monitoring tick.

When the alert pin is low, the master can issue a Receive Byte to the Alert Response Address (seven bits 0001100). The block acknowledges that address only while it is holding its alert low. It then returns its own address in the byte, lets go of the alert pin, and arbitrates bit by bit against any other responders. The block never holds SCL and has no bus timeout. A START followed directly by a STOP puts it back in idle.

Top module: `smb_alert_slave`

## Requirements
- R1: A read to the own address (OWN_ADDR, read bit 1) is acknowledged and returns register byte `regs_i[8*p +: 8]`, MSB first, where p is the current pointer. A master ACK causes the same byte to be sent again.
- R2: A write to the own address (read bit 0) is acknowledged. Its data byte is acknowledged and its low log2(NREG) bits become the pointer. The pointer resets to 0.
- R3: An address byte that matches neither the own address nor the Alert Response Address is not acknowledged. The block then releases SDA for every bit until the next START.
- R4: An Alert Response Address read (byte 0x19) is acknowledged only while `alert_n_o` is low. Otherwise it is not acknowledged.
- R5: The byte sent in reply to the Alert Response Address is {OWN_ADDR, 1'b0}.
- R6: `alert_n_o` goes high as soon as the acknowledge of the Alert Response Address completes, that is, at the ninth SCL falling edge.
- R7: `alert_n_o` goes low only on a `mon_tick_i` cycle with `alert_req_i` high while the block is idle. A tick during a transaction is dropped. Once low, the pin stays low until it is released by R6.
- R8: If SDA reads low while the block is sending a 1 bit, the block stops driving for the rest of the transaction. After an arbitration loss in an alert response, `alert_n_o` is low again.
- R9: A STOP always returns the block to idle. A START followed directly by a STOP leaves it idle, so monitoring ticks are accepted afterwards.
- R10: SCL may be held low by another device for any length of time, beyond 25 ms included, without aborting or corrupting the transfer.
- R11: An acknowledge pulls SDA low from the eighth SCL falling edge to the ninth. SDA pull-down only ever starts while SCL is low.
- R12: SDA is released whenever the block is idle or ignoring the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| regs_i | input | NREG*8 | Readable register bytes, byte p at bits 8p+7:8p |
| alert_req_i | input | 1 | Alert request level from monitoring logic |
| mon_tick_i | input | 1 | One-cycle monitoring-cycle tick |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| alert_n_o | output | 1 | Active-low alert pin |

## Verification
On every cycle, the assertions check four things: SDA is released in idle and ignore states, the pull-down only starts with SCL low, an Alert Response acknowledge is given only while the alert pin is low, and STOP forces idle. They also check that the alert never sets during a transaction except through arbitration-loss restore. The bench scenarios are needed to show the rest: the byte values returned, the pointer update, the alert release at the acknowledge edge and its re-arming at the next tick, the losing arbitration bit pattern, survival of a long SCL stretch, and acceptance of ticks after a START-STOP bus reset.

// File: rtl/smb_slv_pkg.sv
package smb_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK_WAIT, ST_ACK_DRV, ST_TX, ST_TX_ACK, ST_RX, ST_IGNORE
  } smb_st_e;
  localparam logic [6:0] ARA_ADDR = 7'b0001100;
endpackage

// File: rtl/smb_line_mon.sv
module smb_line_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_sync, sda_sync;
  logic       scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_d    <= scl_sync[1];
      sda_d    <= sda_sync[1];
    end
  end

  assign scl_o      = scl_sync[1];
  assign sda_o      = sda_sync[1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA edges with SCL high on both samples
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/smb_alert_ctl.sv
module smb_alert_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic tick_i,
  input  logic busy_i,
  input  logic clr_i,
  input  logic restore_i,
  output logic alert_o
);
  logic alert_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          alert_q <= 1'b0;
    else if (clr_i)                       alert_q <= 1'b0;
    else if (restore_i)                   alert_q <= 1'b1;
    else if (tick_i && req_i && !busy_i)  alert_q <= 1'b1;
  end

  assign alert_o = alert_q;

  // R7: no new alert in the middle of a transaction
  p_no_midxfer_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !restore_i && !alert_q) |=> !alert_q);
endmodule

// File: rtl/smb_alert_slave.sv
module smb_alert_slave
  import smb_slv_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h2D,
  parameter int         NREG     = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic [NREG*8-1:0] regs_i,
  input  logic            alert_req_i,
  input  logic            mon_tick_i,
  output logic            sda_pull_o,
  output logic            alert_n_o
);
  localparam int PW = (NREG > 1) ? $clog2(NREG) : 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  smb_st_e    state_q;
  logic [7:0] sh_q;
  logic [3:0] cnt_q;
  logic       drive_q, rd_q, ara_q, rx_done_q, clr_q, restore_q, alert;
  logic [PW-1:0] ptr_q;
  logic [7:0] tx_byte;

  smb_line_mon u_mon (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  smb_alert_ctl u_alert (
    .clk_i, .rst_ni, .req_i(alert_req_i), .tick_i(mon_tick_i),
    .busy_i(state_q != ST_IDLE), .clr_i(clr_q), .restore_i(restore_q),
    .alert_o(alert)
  );

  assign tx_byte = ara_q ? {OWN_ADDR, 1'b0} : regs_i[8*ptr_q +: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sh_q      <= '0;
      cnt_q     <= '0;
      drive_q   <= 1'b0;
      rd_q      <= 1'b0;
      ara_q     <= 1'b0;
      rx_done_q <= 1'b0;
      clr_q     <= 1'b0;
      restore_q <= 1'b0;
      ptr_q     <= '0;
    end else begin
      clr_q     <= 1'b0;
      restore_q <= 1'b0;
      if (stop_det) begin
        state_q <= ST_IDLE;
        drive_q <= 1'b0;
      end else if (start_det) begin
        state_q   <= ST_ADDR;
        cnt_q     <= '0;
        drive_q   <= 1'b0;
        rx_done_q <= 1'b0;
        ara_q     <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: if (scl_rise) begin
            sh_q  <= {sh_q[6:0], sda_s};
            cnt_q <= cnt_q + 4'd1;
            if (cnt_q == 4'd7) begin
              if (sh_q[6:0] == OWN_ADDR) begin
                state_q <= ST_ACK_WAIT;
                rd_q    <= sda_s;
              end else if (sh_q[6:0] == ARA_ADDR && sda_s && alert) begin
                state_q <= ST_ACK_WAIT;
                rd_q    <= 1'b1;
                ara_q   <= 1'b1;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          ST_ACK_WAIT: if (scl_fall) begin
            drive_q <= 1'b1;
            state_q <= ST_ACK_DRV;
          end
          ST_ACK_DRV: if (scl_fall) begin
            drive_q <= 1'b0;
            cnt_q   <= '0;
            if (rx_done_q) begin
              ptr_q   <= sh_q[PW-1:0];
              state_q <= ST_IGNORE;
            end else if (rd_q) begin
              sh_q    <= tx_byte;
              drive_q <= ~tx_byte[7];
              state_q <= ST_TX;
              clr_q   <= ara_q;
            end else begin
              state_q <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 4'd1;
              if (!drive_q && !sda_s) begin  // sent 1, line low: lost
                state_q   <= ST_IGNORE;
                restore_q <= ara_q;
              end
            end else if (scl_fall) begin
              if (cnt_q == 4'd8) begin
                drive_q <= 1'b0;
                state_q <= ST_TX_ACK;
              end else begin
                sh_q    <= {sh_q[6:0], 1'b0};
                drive_q <= ~sh_q[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise && sda_s) state_q <= ST_IGNORE;
            else if (scl_fall) begin
              sh_q    <= tx_byte;
              drive_q <= ~tx_byte[7];
              cnt_q   <= '0;
              state_q <= ST_TX;
            end
          end
          ST_RX: if (scl_rise) begin
            sh_q  <= {sh_q[6:0], sda_s};
            cnt_q <= cnt_q + 4'd1;
            if (cnt_q == 4'd7) begin
              rx_done_q <= 1'b1;
              state_q   <= ST_ACK_WAIT;
            end
          end
          default: drive_q <= 1'b0;
        endcase
      end
    end
  end

  assign sda_pull_o = drive_q;
  assign alert_n_o  = ~alert;

  // R12: released while idle or ignoring
  p_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE || state_q == ST_IGNORE) |-> !sda_pull_o);
  // R11: pull-down starts only with SCL low
  p_pull_scl_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> !scl_s);
  // R4: alert response acknowledged only while alert pin is low
  p_ara_needs_alert_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_ACK_WAIT || state_q == ST_ACK_DRV) && ara_q) |-> !alert_n_o);
  // R9: STOP returns to idle
  p_stop_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> state_q == ST_IDLE);
endmodule

// File: tb/tb_smb_alert_slave.sv
`timescale 1ns/1ps
module tb_smb_alert_slave;
  localparam int Q = 25;
  localparam logic [6:0] OWN = 7'h2D;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic req = 1'b0, tick = 1'b0;
  logic [31:0] regs = {8'hC3, 8'h96, 8'h3C, 8'hA5};
  logic sda_pull, alert_n;
  wire  sda_line = sda_m & ~sda_pull;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  smb_alert_slave #(.OWN_ADDR(OWN), .NREG(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .regs_i(regs),
    .alert_req_i(req), .mon_tick_i(tick), .sda_pull_o(sda_pull), .alert_n_o(alert_n));

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wc(Q); scl_m = 1'b1; wc(Q); sda_m = 1'b0; wc(Q); scl_m = 1'b0; wc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wc(Q); scl_m = 1'b1; wc(Q); sda_m = 1'b1; wc(Q);
  endtask

  task automatic clk_bit(input logic b, input int stretch, output logic s);
    sda_m = b; wc(Q); if (stretch > 0) wc(stretch);
    scl_m = 1'b1; wc(Q); s = sda_line; wc(Q); scl_m = 1'b0; wc(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack, output int mism);
    logic s;
    mism = 0;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(b[i], 0, s);
      if (s != b[i]) mism++;
    end
    clk_bit(1'b1, 0, s);
    ack = ~s;
  endtask

  task automatic rbyte(input int force_bit, input int stretch_bit, input logic m_ack,
                       output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit((i == force_bit) ? 1'b0 : 1'b1, (i == stretch_bit) ? 30000 : 0, s);
      d[i] = s;
    end
    clk_bit(~m_ack, 0, s);
  endtask

  task automatic pulse_tick();
    tick = 1'b1; wc(1); tick = 1'b0; wc(3);
  endtask

  task automatic ara_clear();
    logic a; int m; logic [7:0] d;
    bus_start(); wbyte(8'h19, a, m); rbyte(-1, -1, 1'b0, d); bus_stop();
  endtask

  task automatic t_reset();
    chk("R12 sda released at reset", sda_pull, 0);
    chk("R7 alert idle at reset", alert_n, 1);
  endtask

  task automatic t_ptr_read();
    logic a; int m; logic [7:0] d;
    bus_start();
    wbyte({OWN, 1'b0}, a, m); chk("R2 write addr ack", a, 1);
    wbyte(8'h02, a, m);       chk("R2 pointer byte ack", a, 1);
    bus_stop();
    bus_start();
    wbyte({OWN, 1'b1}, a, m); chk("R1 read addr ack", a, 1);
    rbyte(-1, -1, 1'b0, d);   chk("R1 read reg2", d, 8'h96);
    bus_stop();
  endtask

  task automatic t_stretch();
    logic a; int m; logic [7:0] d;
    bus_start();
    wbyte({OWN, 1'b1}, a, m); chk("R10 addr ack", a, 1);
    rbyte(-1, 4, 1'b1, d);    chk("R10 byte after long SCL low", d, 8'h96);
    rbyte(-1, -1, 1'b0, d);   chk("R1 repeat after master ack", d, 8'h96);
    bus_stop();
  endtask

  task automatic t_bad_addr();
    logic a; int m;
    bus_start();
    wbyte(8'h22, a, m); chk("R3 foreign addr nack", a, 0); chk("R3 no drive in addr", m, 0);
    wbyte(8'hFF, a, m); chk("R3 data nack", a, 0);        chk("R3 no drive in data", m, 0);
    bus_stop();
    chk("R12 released after stop", sda_pull, 0);
  endtask

  task automatic t_ara_idle();
    logic a; int m;
    bus_start(); wbyte(8'h19, a, m); chk("R4 ARA nack without alert", a, 0); bus_stop();
  endtask

  task automatic t_ara_alert();
    logic a; int m; logic [7:0] d;
    req = 1'b1; pulse_tick();
    chk("R7 alert set on tick", alert_n, 0);
    bus_start();
    wbyte(8'h19, a, m); chk("R4 ARA ack with alert", a, 1);
    chk("R6 alert released after ack", alert_n, 1);
    rbyte(-1, -1, 1'b0, d); chk("R5 ARA byte", d, {OWN, 1'b0});
    bus_stop();
    wc(10); chk("R7 no re-arm without tick", alert_n, 1);
    pulse_tick(); chk("R7 re-armed at tick", alert_n, 0);
  endtask

  task automatic t_busy_tick();
    logic a; int m; logic [7:0] d;
    ara_clear(); chk("R6 cleared for busy test", alert_n, 1);
    bus_start();
    wbyte({OWN, 1'b1}, a, m);
    pulse_tick(); chk("R7 tick ignored mid transfer", alert_n, 1);
    rbyte(-1, -1, 1'b0, d);
    bus_stop();
    chk("R7 still high after transfer", alert_n, 1);
    pulse_tick(); chk("R7 next idle tick sets", alert_n, 0);
  endtask

  task automatic t_arb();
    logic a; int m; logic [7:0] d;
    bus_start();
    wbyte(8'h19, a, m); chk("R8 ARA ack", a, 1);
    rbyte(6, -1, 1'b0, d); chk("R8 lost bit6, rest released", d, 8'h3F);
    bus_stop();
    chk("R8 alert kept after loss", alert_n, 0);
    ara_clear(); chk("R6 clean response releases", alert_n, 1);
  endtask

  task automatic t_bus_reset();
    logic s; logic a; int m; logic [7:0] d;
    bus_start();
    clk_bit(1'b0, 0, s); clk_bit(1'b1, 0, s); clk_bit(1'b0, 0, s);
    pulse_tick(); chk("R7 tick dropped in address phase", alert_n, 1);
    bus_start(); bus_stop();
    pulse_tick(); chk("R9 idle after START-STOP", alert_n, 0);
    ara_clear();
    bus_start(); wbyte({OWN, 1'b1}, a, m); rbyte(-1, -1, 1'b0, d); bus_stop();
    chk("R9 read works after bus reset", d, 8'h96);
    req = 1'b0;
  endtask

  initial begin
    wc(5); rst_n = 1'b1; wc(5);
    t_reset();
    t_ptr_read();
    t_stretch();
    t_bad_addr();
    t_ara_idle();
    t_ara_alert();
    t_busy_tick();
    t_arb();
    t_bus_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule